// File: doc/BRIEF.md
# Write-Protect Programming Sequencer

This block sits behind the command decoder of a small serial non-volatile word store. The decoder hands it one pulse per decoded instruction, carrying an operation code and a word address. The block keeps the software write-enable latch. For word-write and write-all commands it collects the data word from the serial input itself. When chip select falls, it checks the latch and a supply-good flag. If both allow it, it runs a self-timed programming cycle whose length is set by a parameter and drives write strobes into the storage array.

Every programming operation is erase-then-write. An erase phase forces the target word, or every word, to all ones. For the two write operations a second phase then stores the collected word. While the cycle runs, and after it finishes, the status output reports busy (0) or ready (1), but only while chip select is high. A serial-clock rising edge with chip select and data-in both high drops the status indication.

The controller has six states:
- IDLE waits for a command.
- ARMED holds an accepted programming command until chip select falls.
- PROG counts the programming time.
- ERS issues the erase strobes.
- WR issues the write strobes.
- SHOW reports ready.

The transitions are:
- IDLE to ARMED: a programming command arrives.
- ARMED to PROG: chip select falls with the latch set and the supply good.
- ARMED to IDLE: chip select falls without that permission.
- PROG to ERS: the timer expires.
- ERS to WR: the erase phase ends on a write operation.
- ERS to SHOW: the erase phase ends on an erase operation.
- WR to SHOW: the write phase ends.
- SHOW to IDLE: the clear combination is seen.

Chip select, serial clock and data-in are expected to arrive already synchronised to `clk`.

Top module: `wp_prog_seq`

## Requirements
- R1: After reset the enable latch is clear, `arr_we` is low and `status_oe` is low even with chip select high.
- R2: `cmd_op` codes are 0 read, 1 word write, 2 write-all, 3 word erase, 4 erase-all, 5 enable, 6 disable. Enable sets the latch, disable clears it, and read changes neither the latch nor the array.
- R3: A programming command issues no strobe and never drives status if, at the cycle where chip select is sampled falling, the latch is clear or `vdd_ok` is low.
- R4: Nothing is programmed while chip select stays high after a programming command. Only the falling edge of chip select starts the cycle.
- R5: The first strobe comes after exactly PROG_CYCLES cycles in PROG. Ready appears PROG_CYCLES+S clock edges after the edge that samples chip select low, where S is the number of strobes.
- R6: Word erase writes all ones to its address (S=1). Word write writes all ones and then the data to its address (S=2). Erase-all writes all ones to addresses 0 up to DEPTH-1 in ascending order (S=DEPTH). Write-all does that erase sweep and then a data sweep in the same order (S=2*DEPTH).
- R7: After a write command, each serial-clock rise with chip select high shifts data-in into the data word, MSB first. Only the last 16 bits received are stored.
- R8: `status_oe` is high only while chip select is high between the start of a cycle and the clear. `status_do` is 0 while busy and 1 once ready.
- R9: In the ready state, a serial-clock rise with chip select high and data-in high drops `status_oe`. A rise with data-in low does not.
- R10: Commands and the clear combination that arrive while busy are ignored. A disable sent during a cycle leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle pulse marking a decoded command |
| cmd_op | input | 3 | Operation code, encoding in R2 |
| cmd_addr | input | ADDR_W | Target word address |
| cs | input | 1 | Chip select, synchronised |
| sk | input | 1 | Serial clock, synchronised |
| di | input | 1 | Serial data in, synchronised |
| vdd_ok | input | 1 | Supply-good qualifier |
| arr_we | output | 1 | Array write strobe, one word per cycle |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Word written to the array |
| status_oe | output | 1 | Status drive enable; high impedance when low |
| status_do | output | 1 | Status value: 0 busy, 1 ready |

## Verification
The bench targets several corner cases:
- A write longer than 16 bits. A design that kept the first bits would store the wrong word.
- Supply-good low at the falling edge with the latch set. A design checking only the latch would program the array.
- Chip select held high long after a command. A design that starts on command decode would strobe early.
- A disable and a clear combination issued in the middle of a cycle. A design that accepts them would lose write permission or hide the busy status.

The bench also counts the exact cycles to ready for single-word and sweep operations, and checks the first and last strobe of each sweep. A timer off by one, a sweep that skips its last address, or a write without its leading erase would each show up there.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

    typedef enum logic [2:0] {
        OP_RD      = 3'd0,
        OP_WR_WORD = 3'd1,
        OP_WR_ALL  = 3'd2,
        OP_ER_WORD = 3'd3,
        OP_ER_ALL  = 3'd4,
        OP_EN      = 3'd5,
        OP_DIS     = 3'd6,
        OP_NONE    = 3'd7
    } wp_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_PROG  = 3'd2,
        ST_ERS   = 3'd3,
        ST_WR    = 3'd4,
        ST_SHOW  = 3'd5
    } wp_state_e;

    function automatic logic op_is_prog(input wp_op_e op);
        return (op == OP_WR_WORD) || (op == OP_WR_ALL) ||
               (op == OP_ER_WORD) || (op == OP_ER_ALL);
    endfunction

    function automatic logic op_has_data(input wp_op_e op);
        return (op == OP_WR_WORD) || (op == OP_WR_ALL);
    endfunction

    function automatic logic op_is_all(input wp_op_e op);
        return (op == OP_WR_ALL) || (op == OP_ER_ALL);
    endfunction

endpackage

// File: rtl/wp_pin_edges.sv
module wp_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    output logic cs_fall,
    output logic sk_rise
);
    logic cs_q;
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    assign cs_fall = cs_q & ~cs;
    assign sk_rise = sk & ~sk_q;

endmodule

// File: rtl/wp_prog_timer.sv
module wp_prog_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);

    // R5: the timing count never runs past its terminal value
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: an idle timer always restarts from zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/wp_shift_word.sv
module wp_shift_word #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (clr)
            word <= '0;
        else if (en)
            word <= {word[W-2:0], din};
    end

endmodule

// File: rtl/wp_prog_seq.sv
module wp_prog_seq #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              vdd_ok,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              status_oe,
    output logic              status_do
);
    import wp_seq_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    wp_state_e         state_q, state_d;
    wp_op_e            cmd_op_e;
    wp_op_e            op_q;
    logic              wel_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              cs_fall, sk_rise;
    logic              tmr_expire;
    logic [DATA_W-1:0] word;
    logic              accept_prog;
    logic              shift_en;
    logic              clear_combo;
    logic              sweep_end;
    logic              busy;

    assign cmd_op_e    = wp_op_e'(cmd_op);
    assign accept_prog = (state_q == ST_IDLE) && cmd_valid && op_is_prog(cmd_op_e);
    assign shift_en    = (state_q == ST_ARMED) && sk_rise && cs && op_has_data(op_q);
    assign clear_combo = sk_rise && cs && di;
    assign sweep_end   = !op_is_all(op_q) || (ptr_q == LAST_ADDR);
    assign busy        = (state_q == ST_PROG) || (state_q == ST_ERS) || (state_q == ST_WR);

    wp_pin_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .cs_fall (cs_fall),
        .sk_rise (sk_rise)
    );

    wp_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_PROG),
        .expire (tmr_expire)
    );

    wp_shift_word #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept_prog),
        .en    (shift_en),
        .din   (di),
        .word  (word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_prog) state_d = ST_ARMED;
            ST_ARMED: if (cs_fall) state_d = (wel_q && vdd_ok) ? ST_PROG : ST_IDLE;
            ST_PROG:  if (tmr_expire) state_d = ST_ERS;
            ST_ERS:   if (sweep_end) state_d = op_has_data(op_q) ? ST_WR : ST_SHOW;
            ST_WR:    if (sweep_end) state_d = ST_SHOW;
            ST_SHOW:  if (clear_combo) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // enable latch and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
            op_q  <= OP_NONE;
            tgt_q <= '0;
        end else if ((state_q == ST_IDLE) && cmd_valid) begin
            if (cmd_op_e == OP_EN)
                wel_q <= 1'b1;
            else if (cmd_op_e == OP_DIS)
                wel_q <= 1'b0;
            if (op_is_prog(cmd_op_e)) begin
                op_q  <= cmd_op_e;
                tgt_q <= cmd_addr;
            end
        end
    end

    // sweep pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (state_q == ST_PROG)
            ptr_q <= op_is_all(op_q) ? '0 : tgt_q;
        else if (((state_q == ST_ERS) || (state_q == ST_WR)) && op_is_all(op_q))
            ptr_q <= (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
    end

    // outputs
    always_comb begin
        arr_we    = (state_q == ST_ERS) || (state_q == ST_WR);
        arr_addr  = ptr_q;
        arr_wdata = (state_q == ST_WR) ? word : {DATA_W{1'b1}};
        status_oe = cs && (busy || (state_q == ST_SHOW));
        status_do = (state_q == ST_SHOW);
    end

    // R3: a strobe is only issued with write permission held
    a_r3_strobe_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wel_q);

    // R4: a cycle begins only after chip select was sampled falling with permission
    a_r4_start_on_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PROG) && ($past(state_q) != ST_PROG))
            |-> $past(cs_fall && wel_q && vdd_ok));

    // R8: status is never driven with chip select low
    a_r8_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        status_oe |-> cs);

    // R9: the clear combination in the ready state releases the status drive
    a_r9_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHOW) && clear_combo) |=> !status_oe);

    // R10: the latch does not move while a cycle is running
    a_r10_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wel_q));

endmodule

// File: tb/wp_prog_seq_tb.sv
`timescale 1ns/1ps
module wp_prog_seq_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int PC = 40;
    localparam int DEPTH = 64;
    localparam int LIMIT = PC + 2*DEPTH + 20;

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  addr;
        logic [19:0] data;
        logic [4:0]  nbits;
        logic        vdd;
    } vec_t;

    // op codes from R2: 0 rd,1 wr,2 wrall,3 er,4 erall,5 en,6 dis
    localparam vec_t VECS [12] = '{
        '{3'd1, 6'd5,  20'h01234, 5'd16, 1'b1},  // write with latch clear (R1,R3)
        '{3'd5, 6'd0,  20'h0,     5'd0,  1'b1},  // enable
        '{3'd0, 6'd7,  20'h0,     5'd0,  1'b1},  // read, no effect (R2)
        '{3'd1, 6'd5,  20'h0A5C3, 5'd16, 1'b0},  // supply low (R3)
        '{3'd4, 6'd0,  20'h0,     5'd0,  1'b1},  // erase all (R6)
        '{3'd1, 6'd5,  20'h0A5C3, 5'd16, 1'b1},  // word write (R6)
        '{3'd1, 6'd63, 20'hF1234, 5'd20, 1'b1},  // 20 bits, last 16 kept (R7)
        '{3'd3, 6'd5,  20'h0,     5'd0,  1'b1},  // word erase (R6)
        '{3'd2, 6'd9,  20'h00F0F, 5'd16, 1'b1},  // write all (R6)
        '{3'd1, 6'd0,  20'h00000, 5'd16, 1'b1},  // write zero at 0
        '{3'd6, 6'd0,  20'h0,     5'd0,  1'b1},  // disable (R2)
        '{3'd3, 6'd0,  20'h0,     5'd0,  1'b1}   // erase after disable (R3)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, vdd_ok = 1'b1;
    logic arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic status_oe, status_do;

    int checks = 0;
    int errors = 0;
    bit wel_m = 1'b0;
    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] expm [DEPTH];
    logic [AW-1:0] log_a [256];
    logic [DW-1:0] log_d [256];
    int stb_total = 0;

    always #2.5 clk = ~clk;

    wp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cs(cs), .sk(sk), .di(di), .vdd_ok(vdd_ok),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .status_oe(status_oe), .status_do(status_do)
    );

    always @(posedge clk) begin
        if (arr_we) begin
            shadow[arr_addr]         <= arr_wdata;
            log_a[stb_total % 256]   <= arr_addr;
            log_d[stb_total % 256]   <= arr_wdata;
            stb_total                <= stb_total + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] a);
        cmd_op = op; cmd_addr = a; cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic sk_pulse(input logic b);
        di = b; tick();
        sk = 1'b1; tick(); tick();
        sk = 1'b0; di = 1'b0; tick();
    endtask

    // command, data shift, chip select fall, chip select back high
    task automatic start_prog(input logic [2:0] op, input logic [AW-1:0] a,
                              input logic [19:0] d, input int nb, input bit hold_long);
        cs = 1'b1; tick();
        send_cmd(op, a);
        if (op == 3'd1 || op == 3'd2)
            for (int b = nb - 1; b >= 0; b--) sk_pulse(d[b]);
        if (hold_long) begin
            repeat (PC + 20) tick();
            #1;
            chk("R4", "strobes before cs fall", stb_total, 0);
            chk("R4", "status before cs fall", {31'd0, status_oe}, 0);
        end
        cs = 1'b0; tick();
        cs = 1'b1; #1;
    endtask

    task automatic wait_ready(output int m);
        m = 1;
        while (!status_do && m < LIMIT) begin
            tick(); #1; m++;
        end
    endtask

    task automatic clear_status();
        sk_pulse(1'b0); #1;
        chk("R9", "oe kept after di-low rise", {31'd0, status_oe}, 1);
        sk_pulse(1'b1); #1;
        chk("R9", "oe after clear combination", {31'd0, status_oe}, 0);
        cs = 1'b0; tick();
    endtask

    task automatic run_vec(input vec_t v);
        int base, s, m, bad;
        bit exec, all_op, has_d;
        logic [DW-1:0] w;
        w      = v.data[15:0];
        all_op = (v.op == 3'd2) || (v.op == 3'd4);
        has_d  = (v.op == 3'd1) || (v.op == 3'd2);
        vdd_ok = v.vdd;
        base   = stb_total;
        if (!(v.op inside {3'd1, 3'd2, 3'd3, 3'd4})) begin
            cs = 1'b1; tick();
            send_cmd(v.op, v.addr);
            if (v.op == 3'd5) wel_m = 1'b1;
            if (v.op == 3'd6) wel_m = 1'b0;
            cs = 1'b0; tick(); tick();
            chk("R2", "no strobes from non-program op", stb_total - base, 0);
            return;
        end
        exec = wel_m && v.vdd;
        s = (v.op == 3'd1) ? 2 : (v.op == 3'd2) ? 2*DEPTH : (v.op == 3'd3) ? 1 : DEPTH;
        start_prog(v.op, v.addr, v.data, int'(v.nbits), 1'b0);
        if (!exec) begin
            repeat (LIMIT) tick();
            #1;
            chk("R3", "strobes when not permitted", stb_total - base, 0);
            chk("R3", "status when not permitted", {31'd0, status_oe}, 0);
            cs = 1'b0; tick();
            vdd_ok = 1'b1;
            return;
        end
        #0;
        chk("R8", "busy value", {30'd0, status_oe, status_do}, 2'b10);
        wait_ready(m);
        chk("R5", "edges to ready", m, PC + 1 + s);
        chk("R8", "ready value", {30'd0, status_oe, status_do}, 2'b11);
        chk("R6", "strobe count", stb_total - base, s);
        chk("R6", "first strobe addr", log_a[base % 256], all_op ? 0 : v.addr);
        chk("R6", "first strobe is erase", log_d[base % 256], 16'hFFFF);
        chk("R6", "last strobe addr", log_a[(base + s - 1) % 256], all_op ? 63 : v.addr);
        chk(has_d ? "R7" : "R6", "last strobe data", log_d[(base + s - 1) % 256],
            has_d ? w : 16'hFFFF);
        for (int k = 0; k < DEPTH; k++)
            if (all_op || k == int'(v.addr)) expm[k] = has_d ? w : 16'hFFFF;
        bad = 0;
        for (int k = 0; k < DEPTH; k++) if (shadow[k] !== expm[k]) bad++;
        chk("R6", "array mismatches", bad, 0);
        clear_status();
    endtask

    initial begin
        int m, base;
        cs = 1'b1;
        repeat (3) tick();
        #1;
        chk("R1", "oe in reset", {31'd0, status_oe}, 0);
        chk("R1", "we in reset", {31'd0, arr_we}, 0);
        cs = 1'b0;
        rst_n = 1'b1;
        tick(); tick(); #1;
        chk("R1", "we after reset", {31'd0, arr_we}, 0);

        for (int i = 0; i < 12; i++) run_vec(VECS[i]);

        // R4: chip select held high long after the command
        wel_m = 1'b1;
        cs = 1'b1; tick(); send_cmd(3'd5, 6'd0);
        base = stb_total;
        cs = 1'b0; tick();
        begin
            int pre;
            pre = stb_total;
            cs = 1'b1; tick();
            send_cmd(3'd1, 6'd9);
            for (int b = 15; b >= 0; b--) sk_pulse(1'(16'hBEEF >> b));
            repeat (PC + 20) tick();
            #1;
            chk("R4", "strobes while cs high", stb_total - pre, 0);
            chk("R4", "status while cs high", {31'd0, status_oe}, 0);
            cs = 1'b0; tick();
            cs = 1'b1; #1;
        end
        // R10: disable and clear combination during the cycle are ignored
        send_cmd(3'd6, 6'd0);
        sk_pulse(1'b1); #1;
        chk("R10", "status still busy", {30'd0, status_oe, status_do}, 2'b10);
        // R8: chip select low while busy hides the status
        cs = 1'b0; #1;
        chk("R8", "oe with cs low", {31'd0, status_oe}, 0);
        cs = 1'b1; #1;
        wait_ready(m);
        chk("R10", "ready after cycle", {31'd0, status_do}, 1);
        chk("R6", "stored word", shadow[9], 16'hBEEF);
        clear_status();

        base = stb_total;
        start_prog(3'd1, 6'd10, 20'h01357, 16, 1'b0);
        wait_ready(m);
        chk("R10", "latch kept after mid-cycle disable", stb_total - base, 2);
        chk("R10", "word after mid-cycle disable", shadow[10], 16'h1357);
        clear_status();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule